// File: doc/BRIEF.md
# Banked Process-ID Address Relocator

This block is a coprocessor-style control register. It holds a 7-bit process identifier and uses that identifier to relocate low virtual addresses, so that several small processes can share the bottom of the address space without remapping page tables on a context switch. The block keeps two copies of the identifier: one for the secure world and one for the non-secure world. The security-state input picks which copy an access or a relocation uses.

Software reaches the register through a decoded access port that carries opcode and register fields, a read/write flag, the privilege level, the security state and a lock that blocks secure writes. Illegal accesses raise an undefined-instruction flag in the same cycle. Every accepted write sends a one-cycle flush request to the branch target cache. The relocation path is purely combinational: it inserts the active identifier into the top seven address bits whenever those bits are all zero, which is the lowest 32 MB.

Top module: `banked_pid_relocator`

## Requirements
- R1: The port selects this register only when op1 = 0, crn = 13, crm = 0 and op2 = 0. Any other encoding is ignored: no copy changes, the undefined flag stays low, no flush is raised and read data is zero.
- R2: An accepted write stores write-data bits [31:25] as the identifier. An accepted read returns the identifier in bits [31:25] and zero in bits [24:0].
- R3: There are two independent copies. When the security input is 1 the secure copy is selected, and when it is 0 the non-secure copy is selected. An access reads or writes only the selected copy.
- R4: A decoded read or write while the privilege input is 0 raises the undefined flag in the same cycle. It returns zero read data and leaves both copies unchanged.
- R5: A decoded write with privilege 1, security 1 and the secure-write lock at 1 raises the undefined flag and leaves the secure copy unchanged. A non-secure privileged write is not affected by the lock.
- R6: A secure privileged read is accepted while the lock is 1.
- R7: An accepted write produces a flush pulse that is high for exactly the one cycle after the write. In any other cycle the flush pulse is low.
- R8: After reset, both copies are zero.
- R9: When virtual-address bits [31:25] are all zero, the output address is the virtual address with those bits replaced by the active identifier. Otherwise the address passes through unchanged. The output is combinational.
- R10: Relocation uses the copy selected by the present security input. A write changes relocation from the cycle after the write onward, and not in the write cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_op2 | input | 3 | Second opcode field |
| acc_wdata | input | 32 | Write data |
| priv_mode | input | 1 | 1 = privileged, 0 = user |
| sec_state | input | 1 | 1 = secure world, 0 = non-secure world |
| sec_wr_lock | input | 1 | Blocks secure writes when 1 |
| rd_data | output | 32 | Read data, combinational |
| undef_o | output | 1 | Undefined-instruction flag, combinational |
| flush_pulse | output | 1 | Branch-cache flush, registered |
| va_in | input | 32 | Virtual address |
| mva_out | output | 32 | Relocated address, combinational |

## Verification
Read data, the undefined flag and the relocated address are due in the same cycle as the stimulus. The flush pulse is due one cycle after an accepted write, and a stored identifier first shows up in reads and relocation on the cycle after its write. The driver applies inputs just after a rising edge and pushes one expected record per cycle. That record uses the model's identifier values from before the update, and it carries the flush expected from the previous cycle's write. The monitor pops the record and compares all four results at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/bpr_pkg.sv
package bpr_pkg;

  typedef enum logic [1:0] {
    VERDICT_NONE  = 2'd0,
    VERDICT_READ  = 2'd1,
    VERDICT_WRITE = 2'd2,
    VERDICT_UNDEF = 2'd3
  } verdict_e;

  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned BANK_NS   = 0;
  localparam int unsigned BANK_SEC  = 1;

endpackage

// File: rtl/bpr_access_ctrl.sv
module bpr_access_ctrl
  import bpr_pkg::*;
#(
  parameter int unsigned OP1_W   = 3,
  parameter int unsigned CRN_W   = 4,
  parameter int unsigned CRM_W   = 4,
  parameter int unsigned OP2_W   = 3,
  parameter int unsigned SEL_OP1 = 0,
  parameter int unsigned SEL_CRN = 13,
  parameter int unsigned SEL_CRM = 0,
  parameter int unsigned SEL_OP2 = 0
) (
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [OP1_W-1:0] acc_op1,
  input  logic [CRN_W-1:0] acc_crn,
  input  logic [CRM_W-1:0] acc_crm,
  input  logic [OP2_W-1:0] acc_op2,
  input  logic             priv_mode,
  input  logic             sec_state,
  input  logic             sec_wr_lock,
  output verdict_e         verdict,
  output logic             addr_hit,
  output logic             wr_accept,
  output logic             rd_accept,
  output logic             undef
);

  function automatic logic field_match(
    input logic [OP1_W-1:0] o1, input logic [CRN_W-1:0] n,
    input logic [CRM_W-1:0] m,  input logic [OP2_W-1:0] o2);
    return (o1 == OP1_W'(SEL_OP1)) && (n == CRN_W'(SEL_CRN)) &&
           (m == CRM_W'(SEL_CRM)) && (o2 == OP2_W'(SEL_OP2));
  endfunction

  function automatic verdict_e judge(
    input logic hit, input logic wr, input logic priv,
    input logic sec, input logic lock);
    if (!hit)                  return VERDICT_NONE;
    else if (!priv)            return VERDICT_UNDEF;
    else if (wr && sec && lock) return VERDICT_UNDEF;
    else if (wr)               return VERDICT_WRITE;
    else                       return VERDICT_READ;
  endfunction

  always_comb begin
    addr_hit  = acc_valid && field_match(acc_op1, acc_crn, acc_crm, acc_op2);
    verdict   = judge(addr_hit, acc_write, priv_mode, sec_state, sec_wr_lock);
    wr_accept = (verdict == VERDICT_WRITE);
    rd_accept = (verdict == VERDICT_READ);
    undef     = (verdict == VERDICT_UNDEF);
  end

endmodule

// File: rtl/bpr_pid_bank.sv
module bpr_pid_bank
  import bpr_pkg::*;
#(
  parameter int unsigned PID_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             sec_state,
  input  logic [PID_W-1:0] wr_pid,
  output logic [PID_W-1:0] pid_sec,
  output logic [PID_W-1:0] pid_ns,
  output logic [PID_W-1:0] pid_sel
);

  logic [PID_W-1:0] copy_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_we;

  always_comb begin
    bank_we = '0;
    bank_we[sec_state ? BANK_SEC : BANK_NS] = wr_en;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          copy_q[b] <= '0;
      else if (bank_we[b]) copy_q[b] <= wr_pid;
    end
  end

  assign pid_sec = copy_q[BANK_SEC];
  assign pid_ns  = copy_q[BANK_NS];
  assign pid_sel = sec_state ? pid_sec : pid_ns;

endmodule

// File: rtl/bpr_remap.sv
module bpr_remap #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PID_W  = 7
) (
  input  logic [ADDR_W-1:0] va_in,
  input  logic [PID_W-1:0]  pid,
  output logic              in_window,
  output logic [ADDR_W-1:0] mva_out
);

  localparam int unsigned LOW_W = ADDR_W - PID_W;

  function automatic logic [ADDR_W-1:0] relocate(
    input logic [ADDR_W-1:0] va, input logic [PID_W-1:0] id);
    if (va[ADDR_W-1:LOW_W] == '0) return {id, va[LOW_W-1:0]};
    else                          return va;
  endfunction

  assign in_window = (va_in[ADDR_W-1:LOW_W] == '0);
  assign mva_out   = relocate(va_in, pid);

endmodule

// File: rtl/banked_pid_relocator.sv
module banked_pid_relocator
  import bpr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PID_W   = 7,
  parameter int unsigned OP1_W   = 3,
  parameter int unsigned CRN_W   = 4,
  parameter int unsigned CRM_W   = 4,
  parameter int unsigned OP2_W   = 3,
  parameter int unsigned SEL_CRN = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [OP1_W-1:0]  acc_op1,
  input  logic [CRN_W-1:0]  acc_crn,
  input  logic [CRM_W-1:0]  acc_crm,
  input  logic [OP2_W-1:0]  acc_op2,
  input  logic [ADDR_W-1:0] acc_wdata,
  input  logic              priv_mode,
  input  logic              sec_state,
  input  logic              sec_wr_lock,
  output logic [ADDR_W-1:0] rd_data,
  output logic              undef_o,
  output logic              flush_pulse,
  input  logic [ADDR_W-1:0] va_in,
  output logic [ADDR_W-1:0] mva_out
);

  localparam int unsigned LOW_W = ADDR_W - PID_W;

  verdict_e         verdict;
  logic             addr_hit;
  logic             wr_accept;
  logic             rd_accept;
  logic             undef;
  logic [PID_W-1:0] pid_sec;
  logic [PID_W-1:0] pid_ns;
  logic [PID_W-1:0] pid_sel;
  logic             in_window;
  logic             flush_q;
  logic [LOW_W-1:0] wdata_unused;

  assign wdata_unused = acc_wdata[LOW_W-1:0];

  bpr_access_ctrl #(
    .OP1_W(OP1_W), .CRN_W(CRN_W), .CRM_W(CRM_W), .OP2_W(OP2_W),
    .SEL_OP1(0), .SEL_CRN(SEL_CRN), .SEL_CRM(0), .SEL_OP2(0)
  ) u_ctrl (
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_op1    (acc_op1),
    .acc_crn    (acc_crn),
    .acc_crm    (acc_crm),
    .acc_op2    (acc_op2),
    .priv_mode  (priv_mode),
    .sec_state  (sec_state),
    .sec_wr_lock(sec_wr_lock),
    .verdict    (verdict),
    .addr_hit   (addr_hit),
    .wr_accept  (wr_accept),
    .rd_accept  (rd_accept),
    .undef      (undef)
  );

  bpr_pid_bank #(.PID_W(PID_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_accept),
    .sec_state(sec_state),
    .wr_pid   (acc_wdata[ADDR_W-1:LOW_W]),
    .pid_sec  (pid_sec),
    .pid_ns   (pid_ns),
    .pid_sel  (pid_sel)
  );

  bpr_remap #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_remap (
    .va_in    (va_in),
    .pid      (pid_sel),
    .in_window(in_window),
    .mva_out  (mva_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= wr_accept;
  end

  assign flush_pulse = flush_q;
  assign undef_o     = undef;
  assign rd_data     = rd_accept ? {pid_sel, {LOW_W{1'b0}}} : '0;

endmodule

// File: rtl/bpr_checker.sv
module bpr_checker #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PID_W   = 7,
  parameter int unsigned OP1_W   = 3,
  parameter int unsigned CRN_W   = 4,
  parameter int unsigned CRM_W   = 4,
  parameter int unsigned OP2_W   = 3,
  parameter int unsigned SEL_CRN = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [OP1_W-1:0]  acc_op1,
  input logic [CRN_W-1:0]  acc_crn,
  input logic [CRM_W-1:0]  acc_crm,
  input logic [OP2_W-1:0]  acc_op2,
  input logic              priv_mode,
  input logic              sec_state,
  input logic              sec_wr_lock,
  input logic              wr_accept,
  input logic [ADDR_W-1:0] rd_data,
  input logic              undef_o,
  input logic              flush_pulse,
  input logic [ADDR_W-1:0] va_in,
  input logic [ADDR_W-1:0] mva_out,
  input logic [PID_W-1:0]  pid_sec,
  input logic [PID_W-1:0]  pid_ns
);

  localparam int unsigned LOW_W = ADDR_W - PID_W;

  logic decoded;
  assign decoded = acc_valid && (acc_op1 == '0) && (acc_crn == CRN_W'(SEL_CRN)) &&
                   (acc_crm == '0) && (acc_op2 == '0);

  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !decoded |-> !undef_o && !wr_accept && rd_data == '0); // R1
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[LOW_W-1:0] == '0); // R2
  AST_NS_WRITE_SPARES_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && !sec_state) |=> $stable(pid_sec)); // R3
  AST_USER_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (decoded && !priv_mode) |-> undef_o && rd_data == '0); // R4
  AST_USER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (decoded && !priv_mode) |=> $stable(pid_sec) && $stable(pid_ns)); // R4
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (decoded && priv_mode && acc_write && sec_state && sec_wr_lock)
      |=> $stable(pid_sec)); // R5
  AST_FLUSH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> flush_pulse); // R7
  AST_FLUSH_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> !flush_pulse); // R7
  AST_PASSTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (va_in[ADDR_W-1:LOW_W] != '0) |-> mva_out == va_in); // R9
  AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mva_out[LOW_W-1:0] == va_in[LOW_W-1:0]); // R9

endmodule

bind banked_pid_relocator bpr_checker #(
  .ADDR_W(ADDR_W), .PID_W(PID_W), .OP1_W(OP1_W), .CRN_W(CRN_W),
  .CRM_W(CRM_W), .OP2_W(OP2_W), .SEL_CRN(SEL_CRN)
) u_chk (.*);

// File: tb/banked_pid_relocator_tb.sv
module banked_pid_relocator_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 0, acc_write = 0;
  logic [2:0]  acc_op1 = 0, acc_op2 = 0;
  logic [3:0]  acc_crn = 0, acc_crm = 0;
  logic [31:0] acc_wdata = 0;
  logic        priv_mode = 0, sec_state = 0, sec_wr_lock = 0;
  logic [31:0] rd_data, mva_out;
  logic [31:0] va_in = 0;
  logic        undef_o, flush_pulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_pid_relocator u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_op2(acc_op2),
    .acc_wdata(acc_wdata), .priv_mode(priv_mode), .sec_state(sec_state),
    .sec_wr_lock(sec_wr_lock), .rd_data(rd_data), .undef_o(undef_o),
    .flush_pulse(flush_pulse), .va_in(va_in), .mva_out(mva_out)
  );

  typedef struct {
    logic [31:0] rd;
    logic        undef;
    logic        flush;
    logic [31:0] mva;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;

  logic [6:0] m_sec = 0, m_ns = 0;
  logic       m_last_wr = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: one expected record per cycle
  task automatic step(input logic v, input logic w, input logic [2:0] o1,
                      input logic [3:0] n, input logic [3:0] m, input logic [2:0] o2,
                      input logic [31:0] wd, input logic pr, input logic sc,
                      input logic lk, input logic [31:0] va, input string tag);
    exp_t e;
    logic hit, acc_w;
    logic [6:0] act_pid;
    @(posedge clk); #1;
    acc_valid = v; acc_write = w; acc_op1 = o1; acc_crn = n; acc_crm = m;
    acc_op2 = o2; acc_wdata = wd; priv_mode = pr; sec_state = sc;
    sec_wr_lock = lk; va_in = va;
    hit     = v && o1 == 3'd0 && n == 4'd13 && m == 4'd0 && o2 == 3'd0;
    act_pid = sc ? m_sec : m_ns;
    e.tag   = tag;
    e.flush = m_last_wr;
    e.undef = hit && (!pr || (w && sc && lk));
    acc_w   = hit && !e.undef && w;
    e.rd    = (hit && !e.undef && !w) ? {act_pid, 25'd0} : 32'd0;
    e.mva   = (va[31:25] == 7'd0) ? {act_pid, va[24:0]} : va;
    exp_q.push_back(e);
    if (acc_w) begin
      if (sc) m_sec = wd[31:25];
      else    m_ns  = wd[31:25];
    end
    m_last_wr = acc_w;
  endtask

  task automatic wr(input logic sc, input logic pr, input logic lk,
                    input logic [31:0] d, input string tag);
    step(1, 1, 0, 13, 0, 0, d, pr, sc, lk, 32'h0000_1000, tag);
  endtask

  task automatic rd(input logic sc, input logic pr, input logic lk, input string tag);
    step(1, 0, 0, 13, 0, 0, 32'hFFFF_FFFF, pr, sc, lk, 32'h0100_0040, tag);
  endtask

  task automatic idle(input logic sc, input logic [31:0] va, input string tag);
    step(0, 0, 0, 13, 0, 0, 0, 1, sc, 0, va, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, "rd_data", rd_data, e.rd);
      check(e.tag, "undef_o", {31'd0, undef_o}, {31'd0, e.undef});
      check(e.tag, "flush_pulse R7", {31'd0, flush_pulse}, {31'd0, e.flush});
      check(e.tag, "mva_out", mva_out, e.mva);
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R8", "flush in reset", {31'd0, flush_pulse}, 32'd0);
        check("R8", "undef in reset", {31'd0, undef_o}, 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;
        // R8: both copies zero after reset
        rd(1, 1, 0, "R8");
        rd(0, 1, 0, "R8");
        idle(1, 32'h0123_4567, "R9");
        // R2: store top bits, reserved bits read zero
        wr(1, 1, 0, 32'hAB00_1234, "R2");
        idle(1, 32'h0000_0000, "R7");
        rd(1, 1, 0, "R2");
        // R3: non-secure copy independent
        rd(0, 1, 0, "R3");
        wr(0, 1, 0, 32'h0600_0000, "R3");
        rd(0, 1, 0, "R3");
        rd(1, 1, 0, "R3");
        // R4: user mode access
        rd(1, 0, 0, "R4");
        wr(1, 0, 0, 32'hFE00_0000, "R4");
        wr(0, 0, 0, 32'hFE00_0000, "R4");
        rd(1, 1, 0, "R4");
        rd(0, 1, 0, "R4");
        // R5/R6: secure write lock
        wr(1, 1, 1, 32'h1200_0000, "R5");
        rd(1, 1, 1, "R6");
        wr(0, 1, 1, 32'h2400_0000, "R5");
        rd(0, 1, 0, "R5");
        // R1: foreign encodings
        step(1, 1, 0, 12, 0, 0, 32'h8000_0000, 1, 1, 0, 32'h0000_0010, "R1");
        step(1, 1, 0, 13, 0, 1, 32'h8000_0000, 1, 1, 0, 32'h0000_0010, "R1");
        step(1, 1, 1, 13, 0, 0, 32'h8000_0000, 0, 1, 0, 32'h0000_0010, "R1");
        step(1, 0, 0, 13, 1, 0, 32'h8000_0000, 1, 0, 0, 32'h0000_0010, "R1");
        rd(1, 1, 0, "R1");
        // R9: window edges
        idle(1, 32'h01FF_FFFF, "R9");
        idle(1, 32'h0200_0000, "R9");
        idle(1, 32'hFFFF_FFFF, "R9");
        // R10: selection and write visibility
        idle(0, 32'h0000_0ABC, "R10");
        step(1, 1, 0, 13, 0, 0, 32'h7E00_0000, 1, 1, 0, 32'h0000_0ABC, "R10");
        idle(1, 32'h0000_0ABC, "R10");
        idle(0, 32'h0000_0ABC, "R10");
        // R7: back-to-back writes
        wr(0, 1, 0, 32'h0200_0000, "R7");
        wr(0, 1, 0, 32'h0400_0000, "R7");
        idle(0, 32'h0, "R7");
        idle(0, 32'h0, "R7");
        @(posedge clk);
        @(negedge clk);
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule